// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synthesizable model of a synchronous pipelined SRAM whose read and write data phases fall in the same slot relative to the command. A command presented on one clock edge owns the data bus in the cycle that ends two enabled edges later. For a read, data appears after the next enabled edge. For a write, data is sampled on the second enabled edge. Any mix of reads and writes can therefore be issued back to back with no idle cycle between them.

Each command either loads an external address or continues a four-beat burst. The burst continues from the last loaded start address, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. A sleep input gates the core after a two-cycle delay and releases it two cycles after it drops. The array is organised as byte lanes, and each write carries a lane mask. A read that follows a write to the same address on the next cycle gets the new data by forwarding.

Top module: `ztsram_core`

## Requirements
- R1: A read loaded on an enabled edge (clk_en_n low, adv_cont low, cs_n low, we_n high) sets rd_valid, and puts the addressed word on rd_data, right after the next enabled edge, provided oe_n is low.
- R2: A write loaded on an enabled edge takes wr_data on the second enabled edge after it. Lane i is bits [9i+8:9i], and it is updated only when be_n[i] is low on the command edge or on the continuation edge that issued the beat.
- R3: A write whose be_n is all ones changes no array location.
- R4: A read of an address issued on the enabled edge right after a write to that address returns the newly written lanes, merged with the unchanged old lanes.
- R5: While clk_en_n is high, all synchronous inputs are ignored and rd_valid and rd_data keep their values.
- R6: While oe_n is high, rd_valid is low and rd_data is all zeros. A read issued then is a dummy read.
- R7: A load cycle with cs_n high is a deselect and produces no data phase. Continuation cycles that follow a deselect also stay deselected.
- R8: With interleave low, beat n of a burst (n = 0,1,2,3, repeating) uses the start address with its two low bits replaced by (start + n) mod 4.
- R9: With interleave high, beat n uses the start address with its two low bits replaced by start XOR n.
- R10: Once sleep has been high on two consecutive edges, later edges ignore all inputs and rd_valid is low. Commands are accepted again from the second edge after sleep is sampled low. Array contents are kept throughout.
- R11: During and right after reset, rd_valid is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| cs_n | input | 1 | Active-low chip select, sampled on load cycles |
| adv_cont | input | 1 | Low loads addr; high continues the burst |
| addr | input | ADDR_W | External word address |
| we_n | input | 1 | Low selects write on a load cycle |
| be_n | input | LANES | Active-low byte-lane write enables |
| oe_n | input | 1 | Active-low output enable |
| wr_data | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down request |
| rd_data | output | LANES*LANE_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data phase valid and driven |

## Verification
A wrong pipeline stage makes the data slot misalign. Read data then shows up one cycle early or late, or the wrong word lands in the array, which a later read reveals. A stale burst counter or a wrong order shows up at the first continued beat as a neighbouring word. A broken forwarding path returns the old lanes only when a write is followed at once by a read of the same address. A slip in the sleep counter moves the edge on which rd_valid drops or commands are taken by one cycle. Directed sequences pin down each of these edges, and a long random mix compares every cycle against a bench model.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } zt_op_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;
  logic [BURST_W-1:0] step;
  logic [BURST_W-1:0] lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      cnt  <= '0;
    end else if (en) begin
      if (load) begin
        base <= ld_addr;
        cnt  <= '0;
      end else begin
        cnt <= step;
      end
    end
  end

  always_comb begin
    step = cnt + 1'b1;
    lo   = interleave ? (base[BURST_W-1:0] ^ step) : (base[BURST_W-1:0] + step);
    nxt_addr = {base[ADDR_W-1:BURST_W], lo};
  end
endmodule

// File: rtl/zt_sleep_gate.sv
module zt_sleep_gate #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic gate
);
  logic [DLY-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DLY-2:0], sleep};
  end

  assign gate = sr[DLY-1];
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en)      q <= mem[rd_addr];
    end
    assign rd_q[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/ztsram_core.sv
module ztsram_core #(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int BURST_W   = 2,
  parameter int SLEEP_DLY = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    cs_n,
  input  logic                    adv_cont,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we_n,
  input  logic [LANES-1:0]        be_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    interleave,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);
  import zt_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  logic              gate;
  logic              adv;
  logic [ADDR_W-1:0] burst_addr;

  zt_op_e            s1_op, s2_op, nxt_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, nxt_addr;
  logic [LANES-1:0]  s1_mask, s2_mask, nxt_mask;

  logic [DATA_W-1:0] mem_q;
  logic [LANES-1:0]  wr_lane;
  logic [LANES-1:0]  fwd_mask;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] merged;
  logic              q_vld;

  zt_sleep_gate #(.DLY(SLEEP_DLY)) i_gate (
    .clk(clk), .rst(rst), .sleep(sleep), .gate(gate)
  );

  assign adv = !clk_en_n && !gate;

  zt_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_burst (
    .clk(clk), .rst(rst), .en(adv), .load(!adv_cont), .ld_addr(addr),
    .interleave(interleave), .nxt_addr(burst_addr)
  );

  always_comb begin
    nxt_mask = ~be_n;
    if (!adv_cont) begin
      nxt_addr = addr;
      if (cs_n)      nxt_op = OP_IDLE;
      else if (we_n) nxt_op = OP_RD;
      else           nxt_op = OP_WR;
    end else begin
      nxt_addr = burst_addr;
      nxt_op   = s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_mask <= '0;
      s2_mask <= '0;
    end else if (adv) begin
      s1_op   <= nxt_op;
      s1_addr <= nxt_addr;
      s1_mask <= nxt_mask;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
    end
  end

  assign wr_lane = (adv && s2_op == OP_WR) ? s2_mask : '0;

  zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk(clk), .rd_en(adv), .rd_addr(s1_addr), .rd_q(mem_q),
    .wr_lane(wr_lane), .wr_addr(s2_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld    <= 1'b0;
      fwd_mask <= '0;
      fwd_data <= '0;
    end else if (adv) begin
      q_vld    <= (s1_op == OP_RD);
      fwd_mask <= (s1_op == OP_RD && s2_op == OP_WR && s1_addr == s2_addr) ? s2_mask : '0;
      fwd_data <= wr_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = fwd_mask[g] ? fwd_data[g*LANE_W +: LANE_W]
                                                    : mem_q[g*LANE_W +: LANE_W];
  end

  assign rd_valid = q_vld && !oe_n && !gate;
  assign rd_data  = rd_valid ? merged : '0;
endmodule

// File: rtl/ztsram_core_chk.sv
module ztsram_core_chk (
  input logic clk,
  input logic rst,
  input logic clk_en_n,
  input logic cs_n,
  input logic adv_cont,
  input logic we_n,
  input logic oe_n,
  input logic sleep,
  input logic gate,
  input logic q_vld,
  input logic rd_valid
);
  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !gate && !adv_cont && !cs_n && we_n) ##1 (!clk_en_n && !gate) |=> q_vld);

  // R7
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !gate && !adv_cont && cs_n) ##1 (!clk_en_n && !gate) |=> !q_vld);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n || gate) |=> $stable(q_vld));

  // R6
  oe_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rd_valid);

  // R10
  sleep_chk: assert property (@(posedge clk) disable iff (rst)
    sleep ##1 sleep |=> !rd_valid);
endmodule

bind ztsram_core ztsram_core_chk i_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_n(cs_n), .adv_cont(adv_cont),
  .we_n(we_n), .oe_n(oe_n), .sleep(sleep), .gate(gate), .q_vld(q_vld),
  .rd_valid(rd_valid)
);

// File: tb/test_ztsram_core.sv
module test_ztsram_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        clk_en_n, cs_n, adv_cont, we_n, oe_n, interleave, sleep;
  logic [7:0]  addr;
  logic [3:0]  be_n;
  logic [35:0] wr_data;
  logic [35:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ztsram_core i_ztsram_core (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_n(cs_n), .adv_cont(adv_cont),
    .addr(addr), .we_n(we_n), .be_n(be_n), .oe_n(oe_n), .wr_data(wr_data),
    .interleave(interleave), .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Bench model: 0 idle, 1 read, 2 write
  logic [35:0] mmem [256];
  int          p1_op, p2_op;
  logic [7:0]  p1_a, p2_a, bstart;
  logic [3:0]  p1_m, p2_m;
  logic [1:0]  bn, srm;
  logic [35:0] expq;
  logic        expqv;

  function automatic logic [7:0] baddr(input logic [7:0] s, input logic [1:0] n, input logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ n) : (s[1:0] + n);
    return {s[7:2], lo};
  endfunction

  task automatic check(input string tag);
    logic        ev;
    logic [35:0] ed;
    ev = expqv && !oe_n && !srm[1];
    ed = ev ? expq : 36'd0;
    checks++;
    if (rd_valid !== ev || rd_data !== ed) begin
      errors++;
      $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
               tag, rd_valid, rd_data, ev, ed);
    end
  endtask

  task automatic model_edge();
    logic stall;
    stall = clk_en_n || srm[1];
    srm = {srm[0], sleep};
    if (!stall) begin
      if (p2_op == 2) begin
        for (int i = 0; i < 4; i++)
          if (p2_m[i]) mmem[p2_a][i*9 +: 9] = wr_data[i*9 +: 9];
      end
      if (p1_op == 1) expq = mmem[p1_a];
      expqv = (p1_op == 1);
      p2_op = p1_op; p2_a = p1_a; p2_m = p1_m;
      p1_m = ~be_n;
      if (!adv_cont) begin
        p1_op  = cs_n ? 0 : (we_n ? 1 : 2);
        p1_a   = addr;
        bstart = addr;
        bn     = 2'd0;
      end else begin
        bn   = bn + 2'd1;
        p1_a = baddr(bstart, bn, interleave);
      end
    end
  endtask

  task automatic step(input logic cke, input logic cs, input logic cont, input logic we,
                      input logic [3:0] be, input logic [7:0] a, input logic oe,
                      input logic [35:0] wd, input logic slp, input string tag);
    clk_en_n = cke; cs_n = cs; adv_cont = cont; we_n = we; be_n = be;
    addr = a; oe_n = oe; wr_data = wd; sleep = slp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'hf, a, 1'b0, 36'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, be, a, 1'b0, 36'd0, 1'b0, tag);
  endtask

  // Drives the data for a write issued two commands earlier, with a new command.
  task automatic cmd_wd(input logic cs, input logic cont, input logic we, input logic [3:0] be,
                        input logic [7:0] a, input logic [35:0] wd, input string tag);
    step(1'b0, cs, cont, we, be, a, 1'b0, wd, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; clk_en_n = 1'b0; cs_n = 1'b1; adv_cont = 1'b0; we_n = 1'b1;
    be_n = 4'hf; addr = 8'd0; oe_n = 1'b0; wr_data = '0; interleave = 1'b0; sleep = 1'b0;
    p1_op = 0; p2_op = 0; p1_a = 0; p2_a = 0; p1_m = 0; p2_m = 0;
    bstart = 0; bn = 0; srm = 0; expq = 0; expqv = 0;
    for (int i = 0; i < 256; i++) mmem[i] = 36'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 in reset");
    rst = 1'b0;
    idle("R11 after reset");

    // Fill the array: full writes, data two commands later
    for (int i = 0; i < 258; i++) begin
      logic [35:0] d;
      d = {4'h5, 8'(i - 2), 24'h000000} ^ {12'd0, 8'(i - 2), 8'(~(i - 2)), 8'h3c};
      if (i < 256) cmd_wd(1'b0, 1'b0, 1'b0, 4'h0, 8'(i), d, "R2 fill");
      else         cmd_wd(1'b1, 1'b0, 1'b1, 4'hf, 8'd0, d, "R2 fill");
    end

    // R1 / R2: read back a few filled words
    rd(8'd5, "R1"); rd(8'd200, "R1"); idle("R1 data 5"); idle("R1 data 200");

    // R2 lane write: only lane 2
    wr(8'd7, 4'b1011, "R2"); idle("R2"); cmd_wd(1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 36'hfff_fff_fff, "R2");
    rd(8'd7, "R2"); idle("R2 lane2 only");

    // R3 abort
    wr(8'd9, 4'hf, "R3"); idle("R3"); cmd_wd(1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 36'h123_456_789, "R3");
    rd(8'd9, "R3"); idle("R3 unchanged");

    // R4 write then immediate read same address
    wr(8'd11, 4'b0110, "R4"); rd(8'd11, "R4");
    cmd_wd(1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 36'habc_def_012, "R4 forwarded"); idle("R4");

    // R6 dummy read
    rd(8'd20, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b1, 36'd0, 1'b0, "R6 oe high");
    idle("R6");

    // R7 deselect then continuation
    idle("R7");
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, "R7 cont");
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, "R7 cont no phase");
    idle("R7 no phase");

    // R8 linear burst from 0x12: 12,13,10,11
    interleave = 1'b0;
    rd(8'h12, "R8");
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 8'h00, 1'b0, 36'd0, 1'b0, "R8 beat");
    idle("R8 beat"); idle("R8");

    // R9 interleaved burst from 0x25: 25,24,27,26
    interleave = 1'b1;
    rd(8'h25, "R9");
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'hf, 8'h00, 1'b0, 36'd0, 1'b0, "R9 beat");
    idle("R9 beat"); idle("R9");
    interleave = 1'b0;

    // R5 clock enable stall mid-read
    rd(8'd30, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd31, 1'b0, 36'd0, 1'b0, "R5 stalled");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, "R5 resume");
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'hf, 8'd40, 1'b0, 36'd0, 1'b0, "R5 hold data");
    idle("R5"); idle("R5");

    // R10 sleep
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b1, "R10 enter");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b1, "R10 enter");
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd50, 1'b0, 36'hfff_000_fff, 1'b1, "R10 ignored");
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'hf, 8'd50, 1'b0, 36'd0, 1'b1, "R10 ignored read");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, "R10 wake");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hf, 8'd0, 1'b0, 36'd0, 1'b0, "R10 wake");
    rd(8'd50, "R10"); idle("R10 preserved"); idle("R10");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) interleave = $urandom % 2;
      step(($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0, $urandom % 2,
           (($urandom % 3) == 0) ? 4'($urandom) : 4'h0, 8'($urandom),
           ($urandom % 5) == 0, {4'($urandom), 32'($urandom)}, 1'b0,
           "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule